// File: doc/BRIEF.md
# Iterative Signed Word Divider with Overflow and Condition Flags

This unit divides the low halves of two 64-bit integer register values as signed 32-bit numbers. It is meant to sit beside a 64-bit integer pipeline. The quotient goes back sign-extended to the full register width. Each operation carries two control bits. One enables the overflow flags. The other requests a 4-bit condition field derived from the result. The caller also supplies the current overflow (OV) and summary-overflow (SO) bits and receives their updated values.

A division by zero, or the most negative word divided by minus one, yields zero and raises no trap. The overflow flags record the event when they are enabled. The unit is not pipelined. It accepts one operation at a time and asserts done exactly 34 cycles after the accepting clock edge, whatever the operands.

Control is a four-state machine:

- `ST_IDLE` waits for a start.
- `ST_SETUP` forms operand magnitudes and detects the overflow cases.
- `ST_ITER` produces one quotient bit per cycle for 32 cycles.
- `ST_FIX` applies the sign and forms the flags.

Transitions:

- IDLE→SETUP on an accepted start.
- SETUP→ITER unconditionally.
- ITER→ITER while the bit counter is non-zero.
- ITER→FIX when the bit counter reaches zero.
- FIX→IDLE with the done pulse.

Top module: `sdiv_word_unit`

## Requirements
- R1: Only bits [31:0] of each operand are used, read as two's-complement signed values. Bits [63:32] of both operands have no effect on any output.
- R2: The 32-bit quotient is written to `result_o` sign-extended, so `result_o[63:32]` always equals 32 copies of `result_o[31]`.
- R3: The quotient is truncated toward zero. For example, -7 / 2 gives -3, and 100 / -7 gives -14.
- R4: A zero divisor gives a result of 0, and the unit completes normally.
- R5: A dividend of 0x80000000 divided by 0xFFFFFFFF (-1) gives a result of 0, and the unit completes normally.
- R6: With `oe_i`=1, `ov_o` becomes 1 for the R4 and R5 cases and 0 otherwise. `so_o` becomes `so_i` OR the new `ov_o`.
- R7: With `oe_i`=0, `ov_o` and `so_o` equal the `ov_i` and `so_i` values captured with the start.
- R8: With `rc_i`=1, `cond_o` is written with the following bits:
  - bit 3 = LT, meaning the 32-bit result is less than 0.
  - bit 2 = GT, meaning the result is greater than 0.
  - bit 1 = EQ, meaning the result equals 0.
  - bit 0 = the `so_o` value produced by this same operation.
- R9: With `rc_i`=0, `cond_o` keeps the value it had before the operation.
- R10: `done_o` pulses for one cycle exactly 34 clock edges after the edge that accepted the start, including for the R4 and R5 cases.
- R11: `busy_o` is high from the accepting edge until the edge that raises `done_o`. A start while `busy_o` is high is ignored.
- R12: `result_o`, `ov_o`, `so_o` and `cond_o` change only on the edge that raises `done_o`, and hold their values otherwise.
- R13: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an operation; accepted only when not busy |
| op_a_i | input | 64 | Dividend register value (low 32 bits used) |
| op_b_i | input | 64 | Divisor register value (low 32 bits used) |
| oe_i | input | 1 | Enable overflow-flag update for this operation |
| rc_i | input | 1 | Enable condition-field update for this operation |
| ov_i | input | 1 | Incoming overflow bit |
| so_i | input | 1 | Incoming summary-overflow bit |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Sign-extended quotient |
| ov_o | output | 1 | Updated overflow bit |
| so_o | output | 1 | Updated summary-overflow bit |
| cond_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The assertions assume that `start_i`, the operands, the control bits and the incoming flags are valid on the edge where a start is accepted. They also assume that reset is held long enough for every output register to clear before `start_i` is first raised. The stimulus drives every input half a period away from the rising edge. It holds each value through the accepting edge and raises start only at moments the requirements define. Those moments are either when idle, or deliberately while busy to exercise R11. This means that what the checker captures at acceptance always matches what the design captured.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    localparam int unsigned XLEN_DEF = 64;
    localparam int unsigned WLEN_DEF = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } sdiv_state_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } sdiv_cond_t;
endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
    import sdiv_pkg::*;
#(
    parameter int unsigned WLEN = WLEN_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic busy_o
);
    localparam int unsigned CNTW = (WLEN > 1) ? $clog2(WLEN) : 1;
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(WLEN - 1);

    sdiv_state_e     state_q, state_d;
    logic [CNTW-1:0] bit_q, bit_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        accept_o = 1'b0;
        load_o   = 1'b0;
        step_o   = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_SETUP;
                end
            end
            ST_SETUP: begin
                load_o  = 1'b1;
                bit_d   = LAST_BIT;
                state_d = ST_ITER;
            end
            ST_ITER: begin
                step_o = 1'b1;
                if (bit_q == '0) begin
                    state_d = ST_FIX;
                end else begin
                    bit_d = bit_q - 1'b1;
                end
            end
            ST_FIX: begin
                finish_o = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/sdiv_datapath.sv
module sdiv_datapath #(
    parameter int unsigned WLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [WLEN-1:0] dividend_i,
    input  logic [WLEN-1:0] divisor_i,
    output logic [WLEN-1:0] quot_o,
    output logic            ovf_o
);
    localparam logic [WLEN-1:0] MOST_NEG = {1'b1, {(WLEN-1){1'b0}}};
    localparam logic [WLEN-1:0] MINUS_ONE = '1;

    logic [WLEN-1:0] rem_q, quo_q, dvs_q;
    logic            neg_q, ovf_q;

    logic [WLEN-1:0] a_mag, b_mag;
    logic [WLEN:0]   shifted, diff;
    logic            fits;

    assign a_mag = dividend_i[WLEN-1] ? (~dividend_i + 1'b1) : dividend_i;
    assign b_mag = divisor_i[WLEN-1]  ? (~divisor_i + 1'b1)  : divisor_i;

    assign shifted = {rem_q, quo_q[WLEN-1]};
    assign fits    = (shifted >= {1'b0, dvs_q});
    assign diff    = shifted - {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            neg_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= a_mag;
            dvs_q <= b_mag;
            neg_q <= dividend_i[WLEN-1] ^ divisor_i[WLEN-1];
            ovf_q <= (divisor_i == '0) ||
                     ((dividend_i == MOST_NEG) && (divisor_i == MINUS_ONE));
        end else if (step_i) begin
            rem_q <= fits ? diff[WLEN-1:0] : shifted[WLEN-1:0];
            quo_q <= {quo_q[WLEN-2:0], fits};
        end
    end

    always_comb begin
        if (ovf_q) begin
            quot_o = '0;
        end else if (neg_q) begin
            quot_o = ~quo_q + 1'b1;
        end else begin
            quot_o = quo_q;
        end
    end

    assign ovf_o = ovf_q;
endmodule

// File: rtl/sdiv_flags.sv
module sdiv_flags
    import sdiv_pkg::*;
#(
    parameter int unsigned XLEN = XLEN_DEF,
    parameter int unsigned WLEN = WLEN_DEF
) (
    input  logic [WLEN-1:0] quot_i,
    input  logic            ovf_i,
    input  logic            oe_i,
    input  logic            rc_i,
    input  logic            ov_i,
    input  logic            so_i,
    input  logic [3:0]      cond_prev_i,
    output logic [XLEN-1:0] result_o,
    output logic            ov_o,
    output logic            so_o,
    output logic [3:0]      cond_o
);
    sdiv_cond_t fresh;

    assign result_o = {{(XLEN-WLEN){quot_i[WLEN-1]}}, quot_i};

    always_comb begin
        if (oe_i) begin
            ov_o = ovf_i;
            so_o = so_i | ovf_i;
        end else begin
            ov_o = ov_i;
            so_o = so_i;
        end
        fresh.lt = quot_i[WLEN-1];
        fresh.eq = (quot_i == '0);
        fresh.gt = !quot_i[WLEN-1] && (quot_i != '0);
        fresh.so = so_o;
        cond_o   = rc_i ? fresh : cond_prev_i;
    end
endmodule

// File: rtl/sdiv_word_unit.sv
module sdiv_word_unit
    import sdiv_pkg::*;
#(
    parameter int unsigned XLEN = XLEN_DEF,
    parameter int unsigned WLEN = WLEN_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [XLEN-1:0] op_a_i,
    input  logic [XLEN-1:0] op_b_i,
    input  logic            oe_i,
    input  logic            rc_i,
    input  logic            ov_i,
    input  logic            so_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o,
    output logic            ov_o,
    output logic            so_o,
    output logic [3:0]      cond_o
);
    logic            accept, load, step, finish;
    logic [WLEN-1:0] a_q, b_q, quot;
    logic            oe_q, rc_q, ov_in_q, so_in_q, ovf;
    logic [XLEN-1:0] result_d;
    logic            ov_d, so_d;
    logic [3:0]      cond_d;
    logic            unused_hi;

    assign unused_hi = ^{op_a_i[XLEN-1:WLEN], op_b_i[XLEN-1:WLEN]};

    sdiv_ctrl #(.WLEN(WLEN)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .load_o   (load),
        .step_o   (step),
        .finish_o (finish),
        .busy_o   (busy_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            oe_q    <= 1'b0;
            rc_q    <= 1'b0;
            ov_in_q <= 1'b0;
            so_in_q <= 1'b0;
        end else if (accept) begin
            a_q     <= op_a_i[WLEN-1:0];
            b_q     <= op_b_i[WLEN-1:0];
            oe_q    <= oe_i;
            rc_q    <= rc_i;
            ov_in_q <= ov_i;
            so_in_q <= so_i;
        end
    end

    sdiv_datapath #(.WLEN(WLEN)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .dividend_i (a_q),
        .divisor_i  (b_q),
        .quot_o     (quot),
        .ovf_o      (ovf)
    );

    sdiv_flags #(.XLEN(XLEN), .WLEN(WLEN)) u_flags (
        .quot_i      (quot),
        .ovf_i       (ovf),
        .oe_i        (oe_q),
        .rc_i        (rc_q),
        .ov_i        (ov_in_q),
        .so_i        (so_in_q),
        .cond_prev_i (cond_o),
        .result_o    (result_d),
        .ov_o        (ov_d),
        .so_o        (so_d),
        .cond_o      (cond_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o   <= 1'b0;
            result_o <= '0;
            ov_o     <= 1'b0;
            so_o     <= 1'b0;
            cond_o   <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                result_o <= result_d;
                ov_o     <= ov_d;
                so_o     <= so_d;
                cond_o   <= cond_d;
            end
        end
    end
endmodule

// File: rtl/sdiv_word_unit_chk.sv
module sdiv_word_unit_chk #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [XLEN-1:0] op_a_i,
    input logic [XLEN-1:0] op_b_i,
    input logic            oe_i,
    input logic            rc_i,
    input logic            ov_i,
    input logic            so_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o,
    input logic            ov_o,
    input logic            so_o,
    input logic [3:0]      cond_o
);
    localparam int unsigned LAT = WLEN + 2;
    localparam logic [WLEN-1:0] MOST_NEG = {1'b1, {(WLEN-1){1'b0}}};

    logic [WLEN-1:0] a_c, b_c;
    logic            oe_c, rc_c, ov_c, so_c, active;
    logic [7:0]      age;
    logic            zdiv, mneg;
    logic            unused_hi;

    assign unused_hi = ^{op_a_i[XLEN-1:WLEN], op_b_i[XLEN-1:WLEN]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_c <= '0; b_c <= '0; oe_c <= 1'b0; rc_c <= 1'b0;
            ov_c <= 1'b0; so_c <= 1'b0; active <= 1'b0; age <= '0;
        end else if (start_i && !busy_o) begin
            a_c <= op_a_i[WLEN-1:0]; b_c <= op_b_i[WLEN-1:0];
            oe_c <= oe_i; rc_c <= rc_i; ov_c <= ov_i; so_c <= so_i;
            active <= 1'b1; age <= '0;
        end else if (done_o) begin
            active <= 1'b0;
        end else if (active) begin
            age <= age + 1'b1;
        end
    end

    assign zdiv = (b_c == '0);
    assign mneg = (a_c == MOST_NEG) && (b_c == '1);

    p_sext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}});
    p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zdiv) |-> (result_o == '0));
    p_min_neg_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mneg) |-> (result_o == '0));
    p_oe_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && oe_c) |-> ((ov_o == (zdiv || mneg)) && (so_o == (so_c | ov_o))));
    p_oe_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !oe_c) |-> ((ov_o == ov_c) && (so_o == so_c)));
    p_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && rc_c) |-> (($countones(cond_o[3:1]) == 1) && (cond_o[0] == so_o)
            && (cond_o[1] == (result_o == '0)) && (cond_o[3] == result_o[WLEN-1])));
    p_cond_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rc_c) |-> $stable(cond_o));
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (active && (age == 8'(LAT))));
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (active && (age < 8'(LAT))));
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ov_o) && $stable(so_o) && $stable(cond_o)));
endmodule

bind sdiv_word_unit sdiv_word_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) i_chk (.*);

// File: tb/test_sdiv_word_unit.sv
module test_sdiv_word_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [31:0] q;
        logic        ovf;
    } vec_t;

    localparam vec_t VECS [0:NVEC-1] = '{
        {64'd100, 64'd7, 32'd14, 1'b0},
        {64'h0000_0000_FFFF_FF9C, 64'd7, 32'hFFFF_FFF2, 1'b0},
        {64'd100, 64'h0000_0000_FFFF_FFF9, 32'hFFFF_FFF2, 1'b0},
        {64'h0000_0000_FFFF_FF9C, 64'h0000_0000_FFFF_FFF9, 32'd14, 1'b0},
        {64'd7, 64'd100, 32'd0, 1'b0},
        {64'h0000_0000_FFFF_FFF9, 64'd2, 32'hFFFF_FFFD, 1'b0},
        {64'd55, 64'd0, 32'd0, 1'b1},
        {64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 32'd0, 1'b1},
        {64'h0000_0000_8000_0000, 64'd1, 32'h8000_0000, 1'b0},
        {64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 32'h8000_0001, 1'b0},
        {64'hDEAD_BEEF_0000_0064, 64'h1234_5678_FFFF_FFFB, 32'hFFFF_FFEC, 1'b0},
        {64'h0000_0000_8000_0000, 64'd2, 32'hC000_0000, 1'b0},
        {64'd0, 64'h0000_0000_FFFF_FFFD, 32'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic        oe_i = 1'b0, rc_i = 1'b0, ov_i = 1'b0, so_i = 1'b0;
    logic        busy_o, done_o, ov_o, so_o;
    logic [63:0] result_o;
    logic [3:0]  cond_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [3:0] exp_cond = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdiv_word_unit i_sdiv_word_unit (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_q(input logic [31:0] a, input logic [31:0] b);
        logic signed [31:0] sa, sb;
        sa = a; sb = b;
        if (b == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) return 32'd0;
        return 32'(sa / sb);
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic oe, input logic rc,
                          input logic ovv, input logic sov, input logic [31:0] q_exp, input logic ovf_exp);
        int lat;
        logic ov_e, so_e;
        logic [3:0] c_e;
        op_a_i = a; op_b_i = b; oe_i = oe; rc_i = rc; ov_i = ovv; so_i = sov; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = ~a; op_b_i = ~b; oe_i = ~oe; rc_i = ~rc; ov_i = ~ovv; so_i = ~sov;
        lat = 0;
        while (!done_o && lat < 100) begin
            @(posedge clk); @(negedge clk); lat++;
        end
        ov_e = oe ? ovf_exp : ovv;
        so_e = oe ? (sov | ovf_exp) : sov;
        c_e  = rc ? {q_exp[31], !q_exp[31] && q_exp != 0, q_exp == 0, so_e} : exp_cond;
        exp_cond = c_e;
        check(lat == 34, "R10 latency", 64'(lat), 64'd34);
        check(result_o == {{32{q_exp[31]}}, q_exp}, ovf_exp ? "R4 R5 result" : "R1 R2 R3 result",
              result_o, {{32{q_exp[31]}}, q_exp});
        check(ov_o == ov_e && so_o == so_e, oe ? "R6 flags" : "R7 flags",
              {62'd0, ov_o, so_o}, {62'd0, ov_e, so_e});
        check(cond_o == c_e, rc ? "R8 cond" : "R9 cond", 64'(cond_o), 64'(c_e));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && result_o == 0 && ov_o == 0 && so_o == 0 && cond_o == 0,
              "R13 reset", result_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].a, VECS[i].b, i[0], i[1], i[2], i[3], VECS[i].q, VECS[i].ovf);
        end

        // R4 and R5 with both flag updates requested, clean incoming flags
        run_op(64'd123, 64'd0, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 1'b1);
        run_op(64'hFFFF_0000_8000_0000, 64'h0000_FFFF_FFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 32'd0, 1'b1);
        // R6 non-overflow clears OV, keeps sticky SO
        run_op(64'd9, 64'd3, 1'b1, 1'b1, 1'b1, 1'b1, 32'd3, 1'b0);
        // R1 upper halves only differ
        run_op(64'hFFFF_FFFF_0000_0009, 64'h7FFF_0000_0000_0003, 1'b0, 1'b1, 1'b0, 1'b0, 32'd3, 1'b0);

        for (int k = 0; k < 40; k++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (k % 8 == 0) b[31:0] = 0;
            if (k % 8 == 1) begin a[31:0] = 32'h8000_0000; b[31:0] = 32'hFFFF_FFFF; end
            if (k % 8 == 2) b[31:0] = b[31:0] >> 20;
            run_op(a, b, k[0], k[1], k[2], k[3], model_q(a[31:0], b[31:0]),
                   (b[31:0] == 0) || (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF));
        end

        // R12 hold after done
        begin
            logic [63:0] r_s;
            logic [3:0] c_s;
            r_s = result_o; c_s = cond_o;
            repeat (10) @(negedge clk);
            check(result_o == r_s && cond_o == c_s && done_o == 0, "R12 hold", result_o, r_s);
        end

        // R11 start while busy ignored
        begin
            int lat;
            op_a_i = 64'd100; op_b_i = 64'd7; oe_i = 0; rc_i = 1; ov_i = 0; so_i = 0; start_i = 1;
            @(posedge clk); @(negedge clk);
            start_i = 0;
            lat = 0;
            repeat (5) begin @(posedge clk); @(negedge clk); lat++; end
            check(busy_o == 1, "R11 busy", 64'(busy_o), 64'd1);
            op_a_i = 64'd90; op_b_i = 64'd3; rc_i = 0; start_i = 1;
            @(posedge clk); @(negedge clk); lat++;
            start_i = 0;
            while (!done_o && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
            check(lat == 34, "R11 latency unchanged", 64'(lat), 64'd34);
            check(result_o == 64'd14, "R11 result of first op", result_o, 64'd14);
            repeat (40) begin
                @(posedge clk); @(negedge clk);
                if (done_o || busy_o) lat = -1;
            end
            check(lat != -1, "R11 no second op", 64'(busy_o), 64'd0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule